// File: doc/BRIEF.md
# Dual-Compare Programmable Timer

The block is a programmable timer. An up-counter advances on a clock-enable from an external prescaler and is compared against two values that software loads, a set point (A) and a period end (B). When the count reaches A, the timer raises the A interrupt flag and moves its waveform to the active state. When the count reaches B, it raises the B flag, moves the waveform back to idle and restarts the count from zero. This gives a clock or PWM waveform on `tmr_out` whose period and duty are set by B and A.

A fine mode splits each count into two half steps, so the set point can land between two counts. In that mode one waveform period lasts twice as many prescaler ticks. The block enforces the rules for degenerate compare values itself: a set point that lies beyond the period end never fires. The output pin can be inverted, and it can be parked at a fixed level. Software reaches the block through a write-only register port. Each flag is cleared by writing 1 to it.

Top module: `dual_cmp_timer`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, both flags are 0, and every control bit and both compare values are 0, so `tmr_out` is low.
- R2: The counter changes only on a clock edge where `tick_en` is 1 and the run bit is set. While the run bit is clear, the count, the half-step phase and the waveform state are held at 0.
- R3: In normal mode the count steps 0, 1, … B. On the tick taken at count B, the B flag is set and the count reloads to 0, so the period is B+1 ticks. A=0 with B=1 gives the shortest clock, with a period of two ticks.
- R4: In normal mode, the tick taken at count A sets the A flag and makes the waveform active, but only when A ≤ B. When A > B, no A event ever occurs and the waveform stays idle.
- R5: In fine mode each count takes two ticks, a phase-0 tick and a phase-1 tick. The half-step position is 2·count+phase. The A event fires on the tick whose position equals A, and only when A ≤ 2·B+1. The B event and the reload happen on the phase-1 tick at count B, so the period is 2·(B+1) ticks.
- R6: A B event makes the waveform idle. It takes precedence over an A event on the same tick.
- R7: Pin mapping. With the output-enable bit set, `tmr_out` equals the waveform state when the invert bit is 1, and its complement when the invert bit is 0. With the output-enable bit clear, `tmr_out` equals the invert bit.
- R8: Writing 1 to a flag's clear bit clears that flag. An event on the same clock edge wins, and the flag stays set.
- R9: A write to the control register while the run bit is already set leaves the fine-mode bit unchanged. The other control bits still update.
- R10: Register map on `wr_addr`:
  - Address 0 is control: bit0 run, bit1 output enable, bit2 invert, bit3 fine.
  - Address 1 is compare A.
  - Address 2 is compare B.
  - Address 3 is flag clear: bit0 clears the A flag, bit1 clears the B flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaler clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data |
| tmr_out | output | 1 | Timer waveform pin |
| flag_a | output | 1 | Compare-A interrupt flag |
| flag_b | output | 1 | Compare-B interrupt flag |
| count | output | CNT_W | Current counter value |

## Verification
The bench builds the timer with a 4-bit counter (CNT_W = 4). At that width it can sweep every set point from 0 to 7 against every period end from 0 to 5, in both modes, in a few thousand cycles. The sweep covers A = B, A > B and A > 2·B+1, as well as the minimum A=0, B=1 clock. The output-enable and invert settings rotate from one configuration to the next. In fine mode, `tick_en` is dropped on every third cycle so that stalls are exercised. Expected count, waveform and flag values are derived arithmetically from the number of ticks taken since the start.

// File: rtl/dct_pkg.sv
// Shared register map and control-field layout for the dual-compare timer.
// Assumes the data word is at least four bits wide so the control bits fit.
package dct_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CMPA = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CMPB = 2'd2;
    localparam logic [ADDR_W-1:0] REG_CLR  = 2'd3;

    localparam int BIT_RUN  = 0;
    localparam int BIT_OEN  = 1;
    localparam int BIT_INV  = 2;
    localparam int BIT_FINE = 3;

    typedef struct packed {
        logic fine;
        logic inv;
        logic oen;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/dct_regs.sv
// Register file: control bits, the two compare values and the flag-clear strobes.
// Assumes writes are single-cycle strobes. Changes to the mode bit are locked out while running.
module dct_regs
    import dct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b,
    output logic              clr_a,
    output logic              clr_b
);
    // Decode the flag-clear strobes from a write to the clear register.
    always_comb begin
        clr_a = wr_en && (wr_addr == REG_CLR) && wr_data[0];
        clr_b = wr_en && (wr_addr == REG_CLR) && wr_data[1];
    end

    // Hold the control bits and compare values; the mode bit is frozen while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            cmp_a <= '0;
            cmp_b <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: begin
                    ctrl.run <= wr_data[BIT_RUN];
                    ctrl.oen <= wr_data[BIT_OEN];
                    ctrl.inv <= wr_data[BIT_INV];
                    if (!ctrl.run) ctrl.fine <= wr_data[BIT_FINE];
                end
                REG_CMPA: cmp_a <= wr_data;
                REG_CMPB: cmp_b <= wr_data;
                default: ;
            endcase
        end
    end

    // R9: a control write while running keeps the fine-mode bit
    p_mode_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && wr_en && wr_addr == REG_CTRL) |=> $stable(ctrl.fine));
endmodule

// File: rtl/dct_counter.sv
// Up-counter with an optional half-step phase bit. It produces the A and B
// compare events for each tick it takes. Assumes a compare value written
// below the current count ends the period on the next tick.
module dct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fine,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic [CNT_W-1:0] cnt,
    output logic             a_hit,
    output logic             b_hit
);
    localparam int POS_W = CNT_W + 1;

    logic             phase;
    logic             adv;
    logic             at_end;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] a_wide;
    logic [POS_W-1:0] last_pos;
    logic             a_ok_norm;
    logic             a_ok_fine;

    // Form the half-step position and the compare qualifiers.
    always_comb begin
        adv       = run && tick_en;
        pos       = {cnt, phase};
        a_wide    = {1'b0, cmp_a};
        last_pos  = {cmp_b, 1'b1};
        a_ok_norm = (cnt == cmp_a) && (cmp_a <= cmp_b);
        a_ok_fine = (pos == a_wide) && (a_wide <= last_pos);
        at_end    = fine ? (phase && (cnt >= cmp_b)) : (cnt >= cmp_b);
        a_hit     = adv && (fine ? a_ok_fine : a_ok_norm);
        b_hit     = adv && at_end;
    end

    // Advance count and phase on each tick; clear them while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (adv) begin
            if (fine && !phase) begin
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                cnt   <= at_end ? '0 : cnt + 1'b1;
            end
        end
    end

    // R2: a stopped timer has a zero count on the next cycle
    p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
    // R2: without a tick the count holds
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_en) |=> $stable(cnt));
    // R3: the period-end event reloads the count
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        b_hit |=> (cnt == '0));
    // R4: a normal-mode A event only exists for A <= B
    p_a_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && !fine) |-> (cmp_a <= cmp_b));
endmodule

// File: rtl/dct_outgen.sv
// Waveform state, interrupt flags and pin mapping. It consumes the compare
// events and the flag-clear strobes. Assumes the events arrive only while running.
module dct_outgen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic oen,
    input  logic inv,
    input  logic a_hit,
    input  logic b_hit,
    input  logic clr_a,
    input  logic clr_b,
    output logic tmr_out,
    output logic flag_a,
    output logic flag_b
);
    logic act;

    // Track the waveform state: the period end wins over the set point.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) act <= 1'b0;
        else if (b_hit)     act <= 1'b0;
        else if (a_hit)     act <= 1'b1;
    end

    // Update the sticky flags; a new event beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else begin
            if (a_hit)      flag_a <= 1'b1;
            else if (clr_a) flag_a <= 1'b0;
            if (b_hit)      flag_b <= 1'b1;
            else if (clr_b) flag_b <= 1'b0;
        end
    end

    // Map the waveform state onto the pin level.
    always_comb begin
        if (oen) tmr_out = inv ? act : ~act;
        else     tmr_out = inv;
    end

    // R6: the period-end event leaves the waveform idle
    p_b_idles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_hit |=> !act);
    // R4: a lone set-point event makes the waveform active
    p_a_activates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && !b_hit && run) |=> act);
    // R8: an event sets its flag even when a clear arrives with it
    p_event_wins_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        a_hit |=> flag_a);
    p_event_wins_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        b_hit |=> flag_b);
    // R8: a clear with no event drops the flag
    p_clear_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && !a_hit) |=> !flag_a);
endmodule

// File: rtl/dual_cmp_timer.sv
// Top level of the dual-compare timer: register file, counter and output stage.
// Assumes tick_en is a single-cycle enable from an external prescaler and CNT_W >= 4.
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              tmr_out,
    output logic              flag_a,
    output logic              flag_b,
    output logic [CNT_W-1:0]  count
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cmp_a;
    logic [CNT_W-1:0] cmp_b;
    logic             clr_a;
    logic             clr_b;
    logic             a_hit;
    logic             b_hit;

    dct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .clr_a   (clr_a),
        .clr_b   (clr_b)
    );

    dct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .fine    (ctrl.fine),
        .tick_en (tick_en),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .cnt     (count),
        .a_hit   (a_hit),
        .b_hit   (b_hit)
    );

    dct_outgen u_outgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .oen     (ctrl.oen),
        .inv     (ctrl.inv),
        .a_hit   (a_hit),
        .b_hit   (b_hit),
        .clr_a   (clr_a),
        .clr_b   (clr_b),
        .tmr_out (tmr_out),
        .flag_a  (flag_a),
        .flag_b  (flag_b)
    );
endmodule

// File: tb/dual_cmp_timer_tb.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             tmr_out;
    logic             flag_a;
    logic             flag_b;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_cmp_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .tmr_out(tmr_out),
        .flag_a(flag_a), .flag_b(flag_b), .count(count)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs after a falling edge, return after the next falling edge.
    task automatic cycle(input bit tk, input bit we, input int addr, input int data);
        tick_en = tk;
        wr_en   = we;
        wr_addr = addr[1:0];
        wr_data = data[CNT_W-1:0];
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        wr_en   = 1'b0;
    endtask

    // Expected state after k ticks since start (R3, R4, R5, R6).
    task automatic expect_state(input int k, input int a, input int b, input bit fine,
                                output int e_cnt, output int e_act, output int e_fa, output int e_fb);
        int per = fine ? 2 * (b + 1) : b + 1;
        int last = per - 1;
        int q;
        e_cnt = 0; e_act = 0; e_fa = 0; e_fb = 0;
        if (k > 0) begin
            q = (k - 1) % per;
            e_act = (a <= last && a <= q && q < last) ? 1 : 0;
            e_fa  = (a <= last && (k - 1) >= a) ? 1 : 0;
            e_fb  = ((k - 1) >= last) ? 1 : 0;
            if (!fine)       e_cnt = (q == last) ? 0 : q + 1;
            else if (q % 2)  e_cnt = (q == last) ? 0 : (q / 2) + 1;
            else             e_cnt = q / 2;
        end
    endtask

    function automatic int pin_of(input int act, input bit oen, input bit inv);
        if (!oen) return int'(inv);
        return inv ? act : 1 - act;
    endfunction

    task automatic setup(input int a, input int b, input bit fine, input bit oen, input bit inv);
        cycle(1'b0, 1'b1, 0, 0);
        cycle(1'b0, 1'b1, 1, a);
        cycle(1'b0, 1'b1, 2, b);
        cycle(1'b0, 1'b1, 3, 3);
        cycle(1'b0, 1'b1, 0, (int'(fine) << 3) | (int'(inv) << 2) | (int'(oen) << 1) | 1);
    endtask

    task automatic check_all(input string tag, input int k, input int a, input int b,
                             input bit fine, input bit oen, input bit inv);
        int ec, ea, efa, efb;
        expect_state(k, a, b, fine, ec, ea, efa, efb);
        check({tag, " count R3/R5"}, int'(count), ec);
        check({tag, " pin R4/R6/R7"}, int'(tmr_out), pin_of(ea, oen, inv));
        check({tag, " flagA R4/R5"}, int'(flag_a), efa);
        check({tag, " flagB R3"}, int'(flag_b), efb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 count", int'(count), 0);
        check("R1 flagA", int'(flag_a), 0);
        check("R1 flagB", int'(flag_b), 0);
        check("R1 pin", int'(tmr_out), 0);
        // R2: ticks with the run bit clear do nothing
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 0, 0);
        check("R2 stopped count", int'(count), 0);
        check("R2 stopped flagB", int'(flag_b), 0);

        // Sweep: R2..R7, R10 over both modes
        for (int fm = 0; fm < 2; fm++) begin
            for (int b = 0; b <= 5; b++) begin
                for (int a = 0; a <= 7; a++) begin
                    bit oen = ((a + b) % 4) != 3;
                    bit inv = ((a + b + fm) % 2) == 1;
                    int per = fm ? 2 * (b + 1) : b + 1;
                    setup(a, b, fm[0], oen, inv);
                    k = 0;
                    check_all("R2 start", 0, a, b, fm[0], oen, inv);
                    for (int i = 0; i < 3 * per + 3; i++) begin
                        bit tk = !(fm == 1 && (i % 3) == 2);
                        cycle(tk, 1'b0, 0, 0);
                        if (tk) k++;
                        check_all($sformatf("sweep f%0d a%0d b%0d k%0d", fm, a, b, k),
                                  k, a, b, fm[0], oen, inv);
                    end
                end
            end
        end

        // R9: switching to fine mode while running is ignored
        setup(1, 3, 1'b0, 1'b1, 1'b1);
        k = 0;
        cycle(1'b1, 1'b0, 0, 0); k++;
        cycle(1'b1, 1'b0, 0, 0); k++;
        cycle(1'b0, 1'b1, 0, 4'b1111);
        for (int i = 0; i < 8; i++) begin
            cycle(1'b1, 1'b0, 0, 0); k++;
            check_all($sformatf("R9 mode locked k%0d", k), k, 1, 3, 1'b0, 1'b1, 1'b1);
        end

        // R8: clear in the same edge as an A event; the event wins, B clears
        setup(0, 1, 1'b0, 1'b1, 1'b1);
        cycle(1'b1, 1'b0, 0, 0);
        cycle(1'b1, 1'b0, 0, 0);
        check("R8 pre flagA", int'(flag_a), 1);
        check("R8 pre flagB", int'(flag_b), 1);
        cycle(1'b1, 1'b1, 3, 3);
        check("R8 event wins flagA", int'(flag_a), 1);
        check("R8 clear flagB", int'(flag_b), 0);
        check("R3 min clock count", int'(count), 1);
        cycle(1'b0, 1'b1, 3, 1);
        check("R8 clear only A", int'(flag_a), 0);
        cycle(1'b0, 1'b0, 0, 0);
        check("R8 flagB untouched", int'(flag_b), 0);

        // R2: stopping clears the count and parks the waveform
        cycle(1'b1, 1'b0, 0, 0);
        cycle(1'b0, 1'b1, 0, 4'b0110);
        check("R2 stop count", int'(count), 0);
        check("R7 idle inverted pin", int'(tmr_out), 0);
        cycle(1'b0, 1'b1, 0, 4'b0100);
        check("R7 disabled pin equals invert", int'(tmr_out), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule